// File: doc/BRIEF.md
# Memory-mapped GPIO port controller

A 32-pin general-purpose I/O port behind a 32-bit register interface. Software chooses a direction for each pin and drives output data. It reads back pin levels that have passed through a two-flop synchroniser. It also sets a trigger condition for each pin: low level, high level, rising edge or falling edge. An optional per-pin override makes a pin trigger on any edge. Triggered conditions collect in a status register. Software acknowledges them by writing ones to that register. The status is gated by a mask register and drives one or two interrupt request lines.

The bus is a simple single-cycle interface. A write takes effect at the clock edge where `we_i` is high. A read presented with `re_i` returns its data on `rdata_o` after the next clock edge. `rdata_o` is zero in any cycle that follows a cycle without a read. Accesses are always full 32-bit words. Trigger conditions are evaluated on every cycle against the synchronised pad levels. A level condition that is still present therefore raises its status bit again straight after it is acknowledged. Changes to direction, trigger configuration or the any-edge override take effect on the next evaluation.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the data, direction, pad-status, both configuration, mask and any-edge registers read zero. `pad_oe_o`, `pad_o` and `irq_o` are all zero.
- R2: A read of offset 0x00 returns, for each bit, the written data value when that pin's direction bit is 1 (output), and the synchronised pad level when it is 0 (input).
- R3: A read of offset 0x08 returns the synchronised pad level for input pins and zero for output pins.
- R4: `pad_oe_o` equals the direction register (offset 0x04). `pad_o` equals the data register (offset 0x00) ANDed with the direction register.
- R5: The trigger configuration holds 2 bits per pin, in bits [2n+1:2n]. Offset 0x0C holds pins 0-15 and offset 0x10 holds pins 16-31, both read/write. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R6: When a pin's bit in the any-edge register (offset 0x1C) is set, either edge of that pin sets its status bit, overriding its configuration code.
- R7: Writing offset 0x18 clears each status bit written as 1 and leaves bits written as 0 unchanged. A level condition still present sets its bit again at once, so that bit reads back 1.
- R8: Status bits are set only for pins whose direction bit is 0 (input). Pad activity on output pins never sets status.
- R9: With the split option off, `irq_o[0]` is the OR of (status AND mask) over all 32 bits and `irq_o[1]` is 0. With the split option on, `irq_o[0]` covers bits 15:0 and `irq_o[1]` covers bits 31:16.
- R10: With the any-edge option disabled, offset 0x1C reads zero and writes to it have no effect on triggering.
- R11: Offsets other than the eight word offsets 0x00-0x1C, including offsets that are not word-aligned, read zero and leave all registers unchanged when written.
- R12: A mask write (offset 0x14) changes only the request outputs. A mask of zero forces `irq_o` low while the status keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte offset of the access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| pad_i | input | 32 | Pad input levels (asynchronous) |
| pad_o | output | 32 | Pad output data |
| pad_oe_o | output | 32 | Pad output enable, one per pin |
| irq_o | output | 2 | Interrupt request lines |

## Verification
The bench walks each trigger code through the edges that must fire and the edges that must not. A detector with the edge polarity swapped, or with level and edge decoding exchanged, would therefore leave a wrong status pattern. Acknowledging a pin whose high level is still present must read back as set: a design that only clears, and does not evaluate again, would read zero. The bench toggles the pad of an output pin, sets the any-edge override on a rising-edge pin, and runs a second instance with the split lines and without the override. A leak of pad activity into status on output pins, a lost override, or wrong routing of the upper half of the status to a request line would each give an unexpected status or `irq_o` value. Unmapped and misaligned writes are followed by readback of the registers a loose address decoder would hit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_DIR  = 8'h04;
  localparam logic [7:0] OFS_PAD  = 8'h08;
  localparam logic [7:0] OFS_CFGL = 8'h0C;
  localparam logic [7:0] OFS_CFGH = 8'h10;
  localparam logic [7:0] OFS_MASK = 8'h14;
  localparam logic [7:0] OFS_STS  = 8'h18;
  localparam logic [7:0] OFS_ANY  = 8'h1C;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_pkg::*;
(
  input  logic       is_in_i,
  input  logic [1:0] mode_i,
  input  logic       any_edge_i,
  input  logic       cur_i,
  input  logic       nxt_i,
  output logic       hit_o
);
  trig_e mode;
  logic  chg;

  assign mode = trig_e'(mode_i);
  assign chg  = cur_i ^ nxt_i;

  always_comb begin
    hit_o = 1'b0;
    if (is_in_i) begin
      if (any_edge_i) hit_o = chg;
      else begin
        unique case (mode)
          TRIG_LOW:  hit_o = ~nxt_i;
          TRIG_HIGH: hit_o = nxt_i;
          TRIG_RISE: hit_o = chg & nxt_i;
          TRIG_FALL: hit_o = chg & ~nxt_i;
          default:   hit_o = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_eval.sv
module gpio_irq_eval #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]   dir_i,
  input  logic [2*NPINS-1:0] cfg_i,
  input  logic [NPINS-1:0]   any_i,
  input  logic [NPINS-1:0]   cur_i,
  input  logic [NPINS-1:0]   nxt_i,
  output logic [NPINS-1:0]   set_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_detect u_det (
      .is_in_i    (~dir_i[p]),
      .mode_i     (cfg_i[2*p +: 2]),
      .any_edge_i (any_i[p]),
      .cur_i      (cur_i[p]),
      .nxt_i      (nxt_i[p]),
      .hit_o      (set_o[p])
    );
  end
endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out #(
  parameter int NPINS = 32,
  parameter bit SPLIT = 1'b0
) (
  input  logic [NPINS-1:0] sts_i,
  input  logic [NPINS-1:0] msk_i,
  output logic [1:0]       irq_o
);
  localparam int HALF = NPINS / 2;
  logic [NPINS-1:0] act;

  assign act = sts_i & msk_i;

  if (SPLIT) begin : g_split
    assign irq_o[0] = |act[HALF-1:0];
    assign irq_o[1] = |act[NPINS-1:HALF];
  end else begin : g_single
    assign irq_o[0] = |act;
    assign irq_o[1] = 1'b0;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter bit HAS_ANY_EDGE = 1'b1,
  parameter bit SPLIT_IRQ    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] pad_i,
  output logic [DATA_W-1:0] pad_o,
  output logic [DATA_W-1:0] pad_oe_o,
  output logic [1:0]        irq_o
);
  localparam int NPINS = DATA_W;
  localparam int CFG_W = 2 * NPINS;

  logic [NPINS-1:0] dat_q, dir_q, psr_q, msk_q, sts_q, any_q;
  logic [NPINS-1:0] pad_s, sts_set, sts_clr;
  logic [CFG_W-1:0] cfg_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic wr_data, wr_dir, wr_cfgl, wr_cfgh, wr_msk, wr_sts, wr_any;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_data = we_i && hit(addr_i, OFS_DATA);
  assign wr_dir  = we_i && hit(addr_i, OFS_DIR);
  assign wr_cfgl = we_i && hit(addr_i, OFS_CFGL);
  assign wr_cfgh = we_i && hit(addr_i, OFS_CFGH);
  assign wr_msk  = we_i && hit(addr_i, OFS_MASK);
  assign wr_sts  = we_i && hit(addr_i, OFS_STS);
  assign wr_any  = we_i && hit(addr_i, OFS_ANY);

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pad_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      dir_q <= '0;
      psr_q <= '0;
      cfg_q <= '0;
      msk_q <= '0;
      sts_q <= '0;
    end else begin
      psr_q <= pad_s;
      if (wr_data) dat_q <= wdata_i;
      if (wr_dir)  dir_q <= wdata_i;
      if (wr_cfgl) cfg_q[DATA_W-1:0] <= wdata_i;
      if (wr_cfgh) cfg_q[CFG_W-1:DATA_W] <= wdata_i;
      if (wr_msk)  msk_q <= wdata_i;
      // conditions evaluated this cycle win over a same-cycle acknowledge
      sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
  end

  assign sts_clr = wr_sts ? wdata_i : '0;

  if (HAS_ANY_EDGE) begin : g_any
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     any_q <= '0;
      else if (wr_any) any_q <= wdata_i;
    end
  end else begin : g_no_any
    assign any_q = '0;
  end

  gpio_irq_eval #(.NPINS(NPINS)) u_eval (
    .dir_i (dir_q),
    .cfg_i (cfg_q),
    .any_i (any_q),
    .cur_i (psr_q),
    .nxt_i (pad_s),
    .set_o (sts_set)
  );

  gpio_irq_out #(.NPINS(NPINS), .SPLIT(SPLIT_IRQ)) u_irq (
    .sts_i (sts_q),
    .msk_i (msk_q),
    .irq_o (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (hit(addr_i, OFS_DATA)) rd_mux = (dat_q & dir_q) | (psr_q & ~dir_q);
    if (hit(addr_i, OFS_DIR))  rd_mux = dir_q;
    if (hit(addr_i, OFS_PAD))  rd_mux = psr_q & ~dir_q;
    if (hit(addr_i, OFS_CFGL)) rd_mux = cfg_q[DATA_W-1:0];
    if (hit(addr_i, OFS_CFGH)) rd_mux = cfg_q[CFG_W-1:DATA_W];
    if (hit(addr_i, OFS_MASK)) rd_mux = msk_q;
    if (hit(addr_i, OFS_STS))  rd_mux = sts_q;
    if (hit(addr_i, OFS_ANY))  rd_mux = any_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rd_mux : '0;
  end

  assign rdata_o  = rdata_q;
  assign pad_oe_o = dir_q;
  assign pad_o    = dat_q & dir_q;

  assert_pad_follows_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> pad_o == ($past(wdata_i) & pad_oe_o));

  assert_out_pin_no_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sts_q & ~$past(sts_q) & $past(dir_q)) == '0);

  assert_mask_zero_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_msk && wdata_i == '0) |=> irq_o == 2'b00);

  assert_pad_read_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && hit(addr_i, OFS_PAD) && !wr_dir) |=> (rdata_o & pad_oe_o) == '0);

  if (!HAS_ANY_EDGE) begin : g_chk_no_any
    assert_any_absent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i && hit(addr_i, OFS_ANY)) |=> rdata_o == '0);
  end
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  import gpio_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0, pad = '0;
  logic [31:0] rdata, rdata_alt, pad_o, pad_oe, pad_o_alt, pad_oe_alt;
  logic [1:0] irq, irq_alt;

  always #5 clk = ~clk;

  gpio_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .pad_i(pad), .pad_o(pad_o), .pad_oe_o(pad_oe),
    .irq_o(irq));

  gpio_port_ctrl #(.HAS_ANY_EDGE(1'b0), .SPLIT_IRQ(1'b1)) dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata_alt), .pad_i(pad), .pad_o(pad_o_alt),
    .pad_oe_o(pad_oe_alt), .irq_o(irq_alt));

  typedef struct {
    logic [31:0] exp;
    bit          alt;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0, errors = 0;
  bit rd_pend = 1'b0, done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input bit alt, input string tag);
    item_t it;
    it.exp = exp; it.alt = alt; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    pad = v;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) rd_pend <= re;

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) check("scoreboard underflow", 32'h1, 32'h0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, it.alt ? rdata_alt : rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check("watchdog", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state (status excluded: low-level triggers are live at once)
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_o", pad_o, 32'h0);
    check("R1 irq", {30'h0, irq}, 32'h0);
    rd(OFS_DATA, 32'h0, 0, "R1 data");
    rd(OFS_DIR,  32'h0, 0, "R1 dir");
    rd(OFS_PAD,  32'h0, 0, "R1 pad");
    rd(OFS_CFGL, 32'h0, 0, "R1 cfgl");
    rd(OFS_CFGH, 32'h0, 0, "R1 cfgh");
    rd(OFS_MASK, 32'h0, 0, "R1 mask");
    rd(OFS_ANY,  32'h0, 0, "R1 any");

    // R2 R3 R4 direction mixing
    wr(OFS_DIR, 32'h0000_FFFF);
    wr(OFS_DATA, 32'hA5A5_5A5A);
    set_pad(32'h1234_5678);
    check("R4 pad_oe", pad_oe, 32'h0000_FFFF);
    check("R4 pad_o", pad_o, 32'h0000_5A5A);
    rd(OFS_DATA, 32'h1234_5A5A, 0, "R2 data mix");
    rd(OFS_PAD,  32'h1234_0000, 0, "R3 pad status");
    rd(OFS_DIR,  32'h0000_FFFF, 0, "R4 dir");
    wr(OFS_DIR, 32'h0001_0000);
    check("R4 pad_o upper", pad_o, 32'h0001_0000);
    rd(OFS_DATA, 32'hA5A5_5A5A & 32'h0001_0000 | 32'h1234_5678 & ~32'h0001_0000, 0, "R2 data mix 2");

    // R5 trigger codes, R7 acknowledge
    wr(OFS_DIR, 32'h0);
    set_pad(32'h0);
    wr(OFS_CFGL, 32'h5555_555E);  // pin0 rise, pin1 fall, pin2.. high level
    wr(OFS_CFGH, 32'h5555_5556);  // pin16 rise, pin17.. high level
    wr(OFS_STS, 32'hFFFF_FFFF);
    rd(OFS_STS, 32'h0, 0, "R7 clear all");
    check("R9 irq idle", {30'h0, irq}, 32'h0);
    rd(OFS_CFGL, 32'h5555_555E, 0, "R5 cfgl readback");
    rd(OFS_CFGH, 32'h5555_5556, 0, "R5 cfgh readback");
    set_pad(32'h0000_0005);
    rd(OFS_STS, 32'h0000_0005, 0, "R5 rise and high level");
    wr(OFS_STS, 32'h0000_0001);
    rd(OFS_STS, 32'h0000_0004, 0, "R7 clear edge bit");
    wr(OFS_STS, 32'h0000_0004);
    rd(OFS_STS, 32'h0000_0004, 0, "R7 level re-sets");
    wr(OFS_STS, 32'h0);
    rd(OFS_STS, 32'h0000_0004, 0, "R7 zero write no effect");
    set_pad(32'h0000_0004);
    set_pad(32'h0000_0006);
    rd(OFS_STS, 32'h0000_0004, 0, "R5 wrong edges ignored");
    set_pad(32'h0000_0004);
    rd(OFS_STS, 32'h0000_0006, 0, "R5 falling edge");
    set_pad(32'h0001_0004);
    rd(OFS_STS, 32'h0001_0006, 0, "R5 upper rising edge");

    // R6 any-edge override, R10 on the variant without it
    set_pad(32'h0);
    wr(OFS_STS, 32'hFFFF_FFFF);
    rd(OFS_STS, 32'h0, 0, "R7 clear after low");
    wr(OFS_ANY, 32'h0000_0001);
    rd(OFS_ANY, 32'h0000_0001, 0, "R6 readback");
    rd(OFS_ANY, 32'h0, 1, "R10 absent reads zero");
    set_pad(32'h0000_0001);
    wr(OFS_STS, 32'hFFFF_FFFF);
    rd(OFS_STS, 32'h0, 0, "R6 cleared");
    set_pad(32'h0);
    rd(OFS_STS, 32'h0000_0001, 0, "R6 falling edge on rise pin");
    rd(OFS_STS, 32'h0, 1, "R10 write ignored");

    // R8 output pins never set status
    wr(OFS_STS, 32'hFFFF_FFFF);
    wr(OFS_DIR, 32'h0000_0001);
    set_pad(32'h0000_0001);
    rd(OFS_PAD, 32'h0, 0, "R3 output pin reads zero");
    set_pad(32'h0);
    rd(OFS_STS, 32'h0, 0, "R8 output pin toggles");
    wr(OFS_DIR, 32'h0);

    // R9 R12 request lines
    wr(OFS_STS, 32'hFFFF_FFFF);
    set_pad(32'h0001_0000);
    rd(OFS_STS, 32'h0001_0000, 0, "R9 status bit16");
    wr(OFS_MASK, 32'h0001_0000);
    check("R9 single line", {30'h0, irq}, 32'h1);
    check("R9 split upper line", {30'h0, irq_alt}, 32'h2);
    wr(OFS_MASK, 32'h0000_0001);
    check("R12 masked other bit", {30'h0, irq}, 32'h0);
    wr(OFS_MASK, 32'h0);
    check("R12 mask zero", {30'h0, irq}, 32'h0);
    check("R12 mask zero split", {30'h0, irq_alt}, 32'h0);
    rd(OFS_STS, 32'h0001_0000, 0, "R12 status kept");

    // R11 unmapped and misaligned
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h15, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, 0, "R11 unmapped read");
    rd(8'h06, 32'h0, 0, "R11 misaligned read");
    rd(OFS_DIR, 32'h0, 0, "R11 dir untouched");
    rd(OFS_MASK, 32'h0, 0, "R11 mask untouched");
    rd(OFS_DATA, 32'h0001_0000, 0, "R11 data read");
    check("R11 pad_o", pad_o, 32'h0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", sb_q.size(), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule